// File: doc/BRIEF.md
# Parallel NOR Flash Identification Probe

This block masters a 16-bit parallel NOR flash bus for one job: finding out which part is attached. A one-cycle start pulse launches a fixed routine. The block writes the three-word unlock and autoselect command, waits a settle time computed from the clock frequency, then reads the identification words. It accepts exactly one device geometry and reports it. Any other device, or any other maker, is reported as unknown. When the maker was recognised, the routine ends by putting the flash back into normal array read mode.

The bus is a simple synchronous one. Address, write data and the write strobe are valid during one clock cycle. A read strobe held for one cycle returns its data a fixed number of cycles later. The maker code, the mirror marker word, the two extension words, the read latency and the clock frequency are all parameters.

Top module: `nor_id_probe`

## Requirements
- R1: After reset, `busy`, `done`, `fl_we`, `fl_re`, `dev_known`, `sect_count` and `dev_size` are all 0.
- R2: After start, the first three bus operations are writes, in this order: 0x00AA to word address 0x555, 0x0055 to word address 0x2AA, and 0x0090 to word address 0x555.
- R3: No read strobe occurs until at least SETTLE_CYC = (CLK_HZ/1e6)*SETTLE_US cycles after the 0x0090 write.
- R4: The first read is at word address 0x000. Only bits [7:0] of that word are compared with MFR_CODE. On a mismatch the probe reports dev_known=0, sect_count=0 and dev_size=0. It then issues no further read and no further write.
- R5: On a maker match, word address 0x001 is read. If that word differs from MIRROR_CODE, the probe reports dev_known=0, sect_count=0 and dev_size=0x800000.
- R6: If word 0x001 equals MIRROR_CODE, word 0x00E is read and compared with EXT1_CODE. Word 0x00F is read and compared with EXT2_CODE only if 0x00E matched. When both match, the probe reports dev_known=1, sect_count=512 and dev_size=0x02000000. Otherwise the result is the same as in R5.
- R7: Whenever the maker matched, the last bus operation before done is a write of 0x00F0 to word address 0x000.
- R8: Read data is taken from `fl_rdata` exactly RD_LAT cycles after the cycle in which `fl_re` was high.
- R9: `done` is high for exactly one cycle per probe. The result outputs change only in that cycle and hold their values until the next probe's done.
- R10: A start pulse that arrives while `busy` is high is ignored: it adds no bus operation and no done pulse.
- R11: `fl_we` and `fl_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run a probe |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| dev_known | output | 1 | Supported device recognised |
| sect_count | output | SC_W | Reported number of sectors |
| dev_size | output | SIZE_W | Reported device size in bytes |
| fl_addr | output | ADDR_W | Flash word address |
| fl_wdata | output | 16 | Flash write data |
| fl_we | output | 1 | Flash write strobe, one cycle per write |
| fl_re | output | 1 | Flash read strobe, one cycle per read |
| fl_rdata | input | 16 | Flash read data, valid RD_LAT cycles after fl_re |

## Verification
The bench walks every exit of the ID chain.

- **Maker code.** The maker word carries junk in its upper byte. A probe that compared the whole word would reject a valid part.
- **Wrong maker.** This case checks that no read-mode write is issued. A design that always issues one would show four writes instead of three.
- **Mismatch at 0x00E.** A failing match at 0x00E must stop the reads at three. It must report 0x800000 and not 0.
- **Read timing.** The flash model returns garbage outside the exact latency slot. A design that samples one cycle off misclassifies the part.
- **Start while busy.** An extra start during a probe must not produce a second command sequence or a second done.

// File: rtl/nor_probe_pkg.sv
package nor_probe_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_CMD, ST_SETTLE, ST_READ, ST_RWAIT, ST_EXIT, ST_FIN
   } probe_st_t;

   typedef enum logic [1:0] {ID_MFR, ID_DEV, ID_EXT1, ID_EXT2} id_sel_t;

   typedef enum logic [1:0] {V_NOMFR, V_NODEV, V_OK} verdict_t;
endpackage

// File: rtl/nor_probe_settle.sv
module nor_probe_settle #(
   parameter int unsigned CYC = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic expired
);
   generate
      if (CYC == 0) begin : g_none
         assign expired = 1'b1;
      end else begin : g_cnt
         localparam int unsigned CW = $clog2(CYC + 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt <= '0;
            else if (arm)          cnt <= CW'(CYC);
            else if (cnt != '0)    cnt <= cnt - 1'b1;
         end

         assign expired = (cnt == '0);

         // R3
         settle_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            arm |=> !expired);
      end
   endgenerate
endmodule

// File: rtl/nor_probe_rdpipe.sv
module nor_probe_rdpipe #(
   parameter int unsigned LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   output logic hit
);
   logic [LAT-1:0] vp;

   generate
      if (LAT == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vp <= '0;
            else        vp <= issue;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vp <= '0;
            else        vp <= {vp[LAT-2:0], issue};
         end
      end
   endgenerate

   assign hit = vp[LAT-1];

   // R8
   rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(vp) <= 1);
endmodule

// File: rtl/nor_probe_match.sv
module nor_probe_match
   import nor_probe_pkg::*;
#(
   parameter logic [7:0]  MFR_CODE    = 8'h01,
   parameter logic [15:0] MIRROR_CODE = 16'h227E,
   parameter logic [15:0] EXT1_CODE   = 16'h2212,
   parameter logic [15:0] EXT2_CODE   = 16'h2201
) (
   input  id_sel_t     sel,
   input  logic [15:0] word,
   output logic        hit
);
   always_comb begin
      unique case (sel)
         ID_MFR:  hit = (word[7:0] == MFR_CODE);
         ID_DEV:  hit = (word == MIRROR_CODE);
         ID_EXT1: hit = (word == EXT1_CODE);
         default: hit = (word == EXT2_CODE);
      endcase
   end
endmodule

// File: rtl/nor_id_probe.sv
module nor_id_probe
   import nor_probe_pkg::*;
#(
   parameter int unsigned ADDR_W      = 24,
   parameter int unsigned SC_W        = 16,
   parameter int unsigned SIZE_W      = 32,
   parameter int unsigned RD_LAT      = 2,
   parameter int unsigned CLK_HZ      = 100_000_000,
   parameter int unsigned SETTLE_US   = 100,
   parameter int unsigned ACC_SECTORS = 512,
   parameter int unsigned SECT_BYTES  = 32'h10000,
   parameter int unsigned UNK_SIZE    = 32'h800000,
   parameter logic [7:0]  MFR_CODE    = 8'h01,
   parameter logic [15:0] MIRROR_CODE = 16'h227E,
   parameter logic [15:0] EXT1_CODE   = 16'h2212,
   parameter logic [15:0] EXT2_CODE   = 16'h2201
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              dev_known,
   output logic [SC_W-1:0]   sect_count,
   output logic [SIZE_W-1:0] dev_size,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [15:0]       fl_wdata,
   output logic              fl_we,
   output logic              fl_re,
   input  logic [15:0]       fl_rdata
);
   localparam int unsigned SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;
   localparam logic [SIZE_W-1:0] ACC_SIZE = SIZE_W'(ACC_SECTORS * SECT_BYTES);
   localparam logic [SIZE_W-1:0] UNK_SZ   = SIZE_W'(UNK_SIZE);
   localparam logic [SC_W-1:0]   ACC_SC   = SC_W'(ACC_SECTORS);
   localparam logic [ADDR_W-1:0] A_555    = ADDR_W'(12'h555);
   localparam logic [ADDR_W-1:0] A_2AA    = ADDR_W'(12'h2AA);

   generate
      if (RD_LAT < 1)  begin : g_bad_lat  $error("RD_LAT must be at least 1");  end
      if (ADDR_W < 12) begin : g_bad_addr $error("ADDR_W must be at least 12"); end
      if (SC_W < $clog2(ACC_SECTORS + 1)) begin : g_bad_sc $error("SC_W too narrow"); end
   endgenerate

   probe_st_t   st;
   logic [1:0]  step;
   id_sel_t     sel;
   verdict_t    verdict;
   logic        arm, expired, rd_hit, id_hit;

   nor_probe_settle #(.CYC(SETTLE_CYC)) settle_i (
      .clk(clk), .rst_n(rst_n), .arm(arm), .expired(expired));

   nor_probe_rdpipe #(.LAT(RD_LAT)) rdpipe_i (
      .clk(clk), .rst_n(rst_n), .issue(fl_re), .hit(rd_hit));

   nor_probe_match #(
      .MFR_CODE(MFR_CODE), .MIRROR_CODE(MIRROR_CODE),
      .EXT1_CODE(EXT1_CODE), .EXT2_CODE(EXT2_CODE)
   ) match_i (.sel(sel), .word(fl_rdata), .hit(id_hit));

   assign busy  = (st != ST_IDLE);
   assign fl_we = (st == ST_CMD) || (st == ST_EXIT);
   assign fl_re = (st == ST_READ);
   assign arm   = (st == ST_CMD) && (step == 2'd2);

   always_comb begin
      fl_addr  = '0;
      fl_wdata = '0;
      if (st == ST_CMD) begin
         fl_addr = (step == 2'd1) ? A_2AA : A_555;
         unique case (step)
            2'd0:    fl_wdata = 16'h00AA;
            2'd1:    fl_wdata = 16'h0055;
            default: fl_wdata = 16'h0090;
         endcase
      end else if (st == ST_EXIT) begin
         fl_wdata = 16'h00F0;
      end else if (st == ST_READ) begin
         unique case (sel)
            ID_MFR:  fl_addr = ADDR_W'(4'h0);
            ID_DEV:  fl_addr = ADDR_W'(4'h1);
            ID_EXT1: fl_addr = ADDR_W'(4'hE);
            default: fl_addr = ADDR_W'(4'hF);
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         step       <= '0;
         sel        <= ID_MFR;
         verdict    <= V_NOMFR;
         done       <= 1'b0;
         dev_known  <= 1'b0;
         sect_count <= '0;
         dev_size   <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               st   <= ST_CMD;
               step <= '0;
            end
            ST_CMD: begin
               if (step == 2'd2) st <= ST_SETTLE;
               else              step <= step + 1'b1;
            end
            ST_SETTLE: if (expired) begin
               st  <= ST_READ;
               sel <= ID_MFR;
            end
            ST_READ: st <= ST_RWAIT;
            ST_RWAIT: if (rd_hit) begin
               if (id_hit && sel != ID_EXT2) begin
                  sel <= id_sel_t'(sel + 2'd1);
                  st  <= ST_READ;
               end else if (sel == ID_MFR) begin
                  verdict <= V_NOMFR;
                  st      <= ST_FIN;
               end else begin
                  verdict <= id_hit ? V_OK : V_NODEV;
                  st      <= ST_EXIT;
               end
            end
            ST_EXIT: st <= ST_FIN;
            default: begin
               st   <= ST_IDLE;
               done <= 1'b1;
               unique case (verdict)
                  V_OK: begin
                     dev_known  <= 1'b1;
                     sect_count <= ACC_SC;
                     dev_size   <= ACC_SIZE;
                  end
                  V_NODEV: begin
                     dev_known  <= 1'b0;
                     sect_count <= '0;
                     dev_size   <= UNK_SZ;
                  end
                  default: begin
                     dev_known  <= 1'b0;
                     sect_count <= '0;
                     dev_size   <= '0;
                  end
               endcase
            end
         endcase
      end
   end

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable({dev_known, sect_count, dev_size}));

   // R11
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_we && fl_re));

   // R10
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R6
   known_geom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_known |-> (sect_count == ACC_SC && dev_size == ACC_SIZE));
endmodule

// File: tb/nor_id_probe_tb_top.sv
module nor_id_probe_tb_top;
   localparam int AW   = 24;
   localparam int LAT  = 3;
   localparam int SCYC = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic busy, done, dev_known, fl_we, fl_re;
   logic [15:0] sect_count, fl_wdata, fl_rdata;
   logic [31:0] dev_size;
   logic [AW-1:0] fl_addr;

   always #2.5 clk = ~clk;

   nor_id_probe #(
      .ADDR_W(AW), .RD_LAT(LAT), .CLK_HZ(2_000_000), .SETTLE_US(100)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .dev_known(dev_known), .sect_count(sect_count), .dev_size(dev_size),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
      .fl_rdata(fl_rdata));

   int tests = 0, fails = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // flash model
   logic [15:0] id_w [4];
   logic [1:0]  seq;
   logic        auto_md;
   logic [15:0] pd [LAT];

   function automatic logic [15:0] id_word(input logic [AW-1:0] a);
      if (!auto_md) return 16'hFFFF;
      case (a)
         24'h0:   return id_w[0];
         24'h1:   return id_w[1];
         24'hE:   return id_w[2];
         24'hF:   return id_w[3];
         default: return 16'h0000;
      endcase
   endfunction

   always @(posedge clk) begin
      if (fl_we) begin
         if (fl_addr == 24'h555 && fl_wdata == 16'h00AA) seq <= 2'd1;
         else if (seq == 2'd1 && fl_addr == 24'h2AA && fl_wdata == 16'h0055) seq <= 2'd2;
         else if (seq == 2'd2 && fl_addr == 24'h555 && fl_wdata == 16'h0090) begin
            auto_md <= 1'b1; seq <= 2'd0;
         end else if (fl_wdata == 16'h00F0) begin
            auto_md <= 1'b0; seq <= 2'd0;
         end else seq <= 2'd0;
      end
      pd[0] <= fl_re ? id_word(fl_addr) : 16'hDEAD;
      for (int i = 1; i < LAT; i++) pd[i] <= pd[i-1];
   end
   assign fl_rdata = pd[LAT-1];

   // bus log
   int cyc = 0, cmd_cyc = 0, rd1_cyc = 0;
   bit strobe_bad = 0;
   logic [AW-1:0] wa_q[$], ra_q[$];
   logic [15:0]   wd_q[$];

   always @(posedge clk) begin
      cyc++;
      if (fl_we) begin
         wa_q.push_back(fl_addr); wd_q.push_back(fl_wdata);
         if (fl_addr == 24'h555 && fl_wdata == 16'h0090) cmd_cyc = cyc;
      end
      if (fl_re) begin
         ra_q.push_back(fl_addr);
         if (ra_q.size() == 1) rd1_cyc = cyc;
      end
      if (fl_we && fl_re) strobe_bad = 1;
   end

   // scoreboard
   typedef struct { logic k; logic [15:0] c; logic [31:0] s; string req; } exp_t;
   exp_t exp_q[$];
   int done_cnt = 0;
   logic done_prev = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            exp_t e;
            done_cnt++;
            chk(!done_prev, "R9 done width", 1, 0);
            if (exp_q.size() == 0) chk(0, "R10 unexpected done", 1, 0);
            else begin
               e = exp_q.pop_front();
               chk(dev_known == e.k, {e.req, " known"}, dev_known, e.k);
               chk(sect_count == e.c, {e.req, " sectors"}, sect_count, e.c);
               chk(dev_size == e.s, {e.req, " size"}, dev_size, e.s);
            end
         end
         done_prev = done;
      end
   end

   task automatic run_probe(input logic [15:0] w0, w1, w2, w3, input logic ek,
                            input logic [15:0] ec, input logic [31:0] es,
                            input int nrd, input bit rst_wr, input bit poke,
                            input string req);
      exp_t e;
      int d0;
      logic [AW-1:0] ea [4];
      ea[0] = 24'h0; ea[1] = 24'h1; ea[2] = 24'hE; ea[3] = 24'hF;
      id_w[0] = w0; id_w[1] = w1; id_w[2] = w2; id_w[3] = w3;
      wa_q.delete(); wd_q.delete(); ra_q.delete(); strobe_bad = 0;
      e.k = ek; e.c = ec; e.s = es; e.req = req;
      exp_q.push_back(e);
      d0 = done_cnt;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      if (poke) begin
         repeat (5) @(negedge clk);
         start = 1'b1;
         @(negedge clk) start = 1'b0;
      end
      while (done_cnt == d0) @(negedge clk);
      repeat (10) @(negedge clk);
      chk(done_cnt == d0 + 1, "R10 done count", done_cnt - d0, 1);
      chk(wa_q.size() == (rst_wr ? 4 : 3), "R7 write count", wa_q.size(), rst_wr ? 4 : 3);
      if (wa_q.size() >= 3)
         chk(wa_q[0] == 24'h555 && wd_q[0] == 16'h00AA && wa_q[1] == 24'h2AA &&
             wd_q[1] == 16'h0055 && wa_q[2] == 24'h555 && wd_q[2] == 16'h0090,
             "R2 unlock sequence", {wa_q[1], wd_q[1]}, {24'h2AA, 16'h0055});
      if (rst_wr && wa_q.size() == 4)
         chk(wa_q[3] == 24'h0 && wd_q[3] == 16'h00F0, "R7 read-mode write",
             {wa_q[3], wd_q[3]}, {24'h0, 16'h00F0});
      chk(ra_q.size() == nrd, "R4 R6 read count", ra_q.size(), nrd);
      for (int i = 0; i < ra_q.size() && i < 4; i++)
         chk(ra_q[i] == ea[i], "R4 R6 read address", ra_q[i], ea[i]);
      chk(rd1_cyc - cmd_cyc >= SCYC, "R3 settle gap", rd1_cyc - cmd_cyc, SCYC);
      chk(!strobe_bad, "R11 strobe overlap", strobe_bad, 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      chk(0, "R9 watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic k0; logic [15:0] c0; logic [31:0] s0;
      repeat (4) @(negedge clk);
      chk(!busy && !done && !fl_we && !fl_re, "R1 idle outputs",
          {busy, done, fl_we, fl_re}, 0);
      chk(!dev_known && sect_count == 0 && dev_size == 0, "R1 reset results",
          dev_size, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R6 R8 R10: accepted device, upper byte of maker word ignored, extra start
      run_probe(16'hC301, 16'h227E, 16'h2212, 16'h2201, 1, 512, 32'h02000000,
                4, 1, 1, "R6 accept");
      // R4: wrong maker, no read-mode write
      run_probe(16'h0020, 16'h227E, 16'h2212, 16'h2201, 0, 0, 0, 1, 0, 0, "R4 maker");
      // R5: device word mismatch
      run_probe(16'h0001, 16'h1234, 16'h2212, 16'h2201, 0, 0, 32'h800000,
                2, 1, 0, "R5 device");
      // R6: first extension mismatch, 0x00F not read
      run_probe(16'h0001, 16'h227E, 16'h2299, 16'h2201, 0, 0, 32'h800000,
                3, 1, 0, "R6 ext1");
      // R6: second extension mismatch
      run_probe(16'h0001, 16'h227E, 16'h2212, 16'h2288, 0, 0, 32'h800000,
                4, 1, 0, "R6 ext2");
      // R9: results hold between probes
      k0 = dev_known; c0 = sect_count; s0 = dev_size;
      repeat (40) @(negedge clk);
      chk(dev_known == k0 && sect_count == c0 && dev_size == s0, "R9 hold",
          dev_size, s0);
      run_probe(16'h5501, 16'h227E, 16'h2212, 16'h2201, 1, 512, 32'h02000000,
                4, 1, 0, "R6 accept again");
      chk(exp_q.size() == 0, "R9 pending results", exp_q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule